// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator with Register Port

This block generates a pulse-width modulated output. Its period and its high time are both set in counts of a prescaled tick. Software programs it through a small single-cycle register port. A write takes effect on the clock edge where the write strobe is high. A read returns data combinationally for the address presented.

Counting is driven by one of two tick sources. Both arrive as enable strobes synchronous to `clk`, so the block runs on a single clock. A control field selects the source. A programmable prescaler divides the selected ticks. An up-counter then walks through each output period.

The active duty and period values are shadowed. Software can retune a running output without producing a malformed period. Three low-power or debug request inputs can freeze the counter. Each request has its own control bit that allows running through that state.

Top module: `pwm_gen`

## Requirements
- R1: After reset, every register reads as zero and `pwm_out` is low.
- R2: The control register is at byte address 0x00, the duty register at 0x0C and the period register at 0x10. Each reads back the bits last written, with unused bits reading zero. In the control register the implemented bits are 0, 15:4, 17:16, 22, 23 and 24, which gives a read mask of 0x01C3FFF1. The duty and period registers implement bits CNT_W-1:0. Any other address reads zero.
- R3: With enable set, one output period lasts (period + 2) prescaled ticks.
- R4: Within each period, `pwm_out` is high for the first `duty` prescaled ticks and low for the rest.
- R5: A duty of zero holds the output constantly low. A duty of period+2 or more holds it constantly high.
- R6: Control bits 15:4 hold the divide ratio minus one, so one prescaled tick spans (field + 1) selected source ticks.
- R7: Control bits 17:16 select the tick source. Value 1 selects `std_tick` and value 2 selects `fast_tick`. Values 0 and 3 supply no ticks, so the counter stays where it is.
- R8: Duty and period values written while the output runs take effect only at the next period boundary.
- R9: Control bit 0 is the enable. While it is clear, the counters are held at zero and the output is low. Setting it starts a fresh period from its first tick.
- R10: The counters freeze and the output holds its level while a request input is high and its run bit is clear. The pairings are `doze_req` with bit 24, `wait_req` with bit 23 and `dbg_halt` with bit 22. With the run bit set, the request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| std_tick | input | 1 | Standard-rate tick strobe |
| fast_tick | input | 1 | High-rate tick strobe |
| doze_req | input | 1 | Doze state request |
| wait_req | input | 1 | Wait state request |
| dbg_halt | input | 1 | Debug halt request |
| pwm_out | output | 1 | Modulated output |

## Verification
The waveform is compared sample by sample against a computed pattern for several (period, duty, prescale) triples. These distinguish the plus-two period offset from the ratio-minus-one prescale. The duty settings of zero, exactly period+2 and beyond period+2 separate the clamping cases from ordinary compares. A duty rewrite in mid-period shows whether the shadow load waits for the boundary. Source select 0 and the request inputs, tried with each run bit both clear and set, show whether counting really stops and whether the output level is held.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

   localparam logic [7:0] OFS_CTRL = 8'h00;
   localparam logic [7:0] OFS_DUTY = 8'h0C;
   localparam logic [7:0] OFS_PER  = 8'h10;

   localparam int CTL_EN     = 0;
   localparam int CTL_PS_LO  = 4;
   localparam int PS_W       = 12;
   localparam int CTL_SRC_LO = 16;
   localparam int CTL_DBG    = 22;
   localparam int CTL_WAIT   = 23;
   localparam int CTL_DOZE   = 24;

   typedef enum logic [1:0] {
      SRC_OFF  = 2'd0,
      SRC_STD  = 2'd1,
      SRC_FAST = 2'd2,
      SRC_RSV  = 2'd3
   } src_sel_e;

   typedef struct packed {
      logic            doze_run;
      logic            wait_run;
      logic            dbg_run;
      src_sel_e        src;
      logic [PS_W-1:0] presc;
      logic            en;
   } ctrl_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output ctrl_t             ctrl_q,
   output logic [CNT_W-1:0]  duty_q,
   output logic [CNT_W-1:0]  per_q
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(OFS_DUTY);
   localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(OFS_PER);

   wire unused_wdata = ^bus_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         duty_q <= '0;
         per_q  <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            A_CTRL: begin
               ctrl_q.en       <= bus_wdata[CTL_EN];
               ctrl_q.presc    <= bus_wdata[CTL_PS_LO +: PS_W];
               ctrl_q.src      <= src_sel_e'(bus_wdata[CTL_SRC_LO +: 2]);
               ctrl_q.dbg_run  <= bus_wdata[CTL_DBG];
               ctrl_q.wait_run <= bus_wdata[CTL_WAIT];
               ctrl_q.doze_run <= bus_wdata[CTL_DOZE];
            end
            A_DUTY:  duty_q <= bus_wdata[CNT_W-1:0];
            A_PER:   per_q  <= bus_wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: begin
            bus_rdata[CTL_EN]              = ctrl_q.en;
            bus_rdata[CTL_PS_LO +: PS_W]   = ctrl_q.presc;
            bus_rdata[CTL_SRC_LO +: 2]     = ctrl_q.src;
            bus_rdata[CTL_DBG]             = ctrl_q.dbg_run;
            bus_rdata[CTL_WAIT]            = ctrl_q.wait_run;
            bus_rdata[CTL_DOZE]            = ctrl_q.doze_run;
         end
         A_DUTY:  bus_rdata[CNT_W-1:0] = duty_q;
         A_PER:   bus_rdata[CNT_W-1:0] = per_q;
         default: bus_rdata = '0;
      endcase
   end

   // R2: a duty write is stored one edge later
   a_r2_duty_store: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_DUTY) |=> duty_q == $past(bus_wdata[CNT_W-1:0]));

   // R2: a period write is stored one edge later
   a_r2_per_store: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_PER) |=> per_q == $past(bus_wdata[CNT_W-1:0]));

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
   import pwm_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  src_sel_e        src,
   input  logic [PS_W-1:0] presc,
   input  logic            std_tick,
   input  logic            fast_tick,
   input  logic            freeze,
   output logic            ptick
);

   logic            src_tick;
   logic            run;
   logic [PS_W-1:0] pcnt;
   logic            at_end;

   always_comb begin
      case (src)
         SRC_STD:  src_tick = std_tick;
         SRC_FAST: src_tick = fast_tick;
         default:  src_tick = 1'b0;
      endcase
   end

   assign run    = en && src_tick && !freeze;
   assign at_end = (pcnt >= presc);
   assign ptick  = run && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         pcnt <= '0;
      end else if (run) begin
         pcnt <= at_end ? '0 : pcnt + 1'b1;
      end
   end

   // R7: an unclocked source never yields a prescaled tick
   a_r7_no_source: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_OFF || src == SRC_RSV) |-> !ptick);

   // R10: a frozen block neither ticks nor advances the prescaler
   a_r10_freeze_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (en && freeze) |=> (!en || $stable(pcnt)));

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
   parameter int CNT_W   = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             ptick,
   input  logic [CNT_W-1:0] duty_q,
   input  logic [CNT_W-1:0] per_q,
   output logic             pwm_out
);

   logic [CNT_W:0]   cnt;
   logic [CNT_W-1:0] act_duty;
   logic [CNT_W-1:0] act_per;
   logic [CNT_W:0]   last_val;
   logic             last;
   logic             wrap;
   logic             raw;

   assign last_val = {1'b0, act_per} + 1'b1;
   assign last     = (cnt == last_val);
   assign wrap     = ptick && last;
   assign raw      = en && (cnt < {1'b0, act_duty});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         act_duty <= '0;
         act_per  <= '0;
      end else if (!en || wrap) begin
         cnt      <= '0;
         act_duty <= duty_q;
         act_per  <= per_q;
      end else if (ptick) begin
         cnt <= cnt + 1'b1;
      end
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) pwm_out <= 1'b0;
         else        pwm_out <= raw;
      end
   end else begin : g_out_comb
      assign pwm_out = raw;
   end

   // R3: the counter never passes the last count of the period
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= last_val);

   // R9: a period begins at count zero after enable was low
   a_r9_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> cnt == '0);

   // R8: active values change only at a boundary while running
   a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !$past(wrap)) |-> ($stable(act_duty) && $stable(act_per)));

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
   import pwm_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              std_tick,
   input  logic              fast_tick,
   input  logic              doze_req,
   input  logic              wait_req,
   input  logic              dbg_halt,
   output logic              pwm_out
);

   if (DATA_W < CTL_DOZE + 1) begin : g_bad_data
      $error("pwm_gen: DATA_W too small for control fields");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("pwm_gen: CNT_W out of range");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("pwm_gen: ADDR_W cannot decode the register offsets");
   end

   ctrl_t            ctrl;
   logic [CNT_W-1:0] duty_q;
   logic [CNT_W-1:0] per_q;
   logic             freeze;
   logic             ptick;

   pwm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ctrl_q    (ctrl),
      .duty_q    (duty_q),
      .per_q     (per_q)
   );

   assign freeze = (doze_req && !ctrl.doze_run) ||
                   (wait_req && !ctrl.wait_run) ||
                   (dbg_halt && !ctrl.dbg_run);

   pwm_tick_gen u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ctrl.en),
      .src       (ctrl.src),
      .presc     (ctrl.presc),
      .std_tick  (std_tick),
      .fast_tick (fast_tick),
      .freeze    (freeze),
      .ptick     (ptick)
   );

   pwm_wave #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_wave (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ctrl.en),
      .ptick   (ptick),
      .duty_q  (duty_q),
      .per_q   (per_q),
      .pwm_out (pwm_out)
   );

   if (!OUT_REG) begin : g_hold_chk
      // R10: the output level is held across a frozen cycle
      a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl.en && freeze) |=> (!ctrl.en || $stable(pwm_out)));
   end

   // R9: output is low whenever enable is clear
   a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.en |-> !pwm_out);

endmodule

// File: tb/pwm_gen_bench.sv
`timescale 1ns/1ps
module pwm_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        std_tick = 1'b1;
   logic        fast_tick = 1'b0;
   logic        doze_req = 1'b0;
   logic        wait_req = 1'b0;
   logic        dbg_halt = 1'b0;
   logic        pwm_out;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   pwm_gen u_pwm_gen (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .std_tick(std_tick),
      .fast_tick(fast_tick), .doze_req(doze_req), .wait_req(wait_req),
      .dbg_halt(dbg_halt), .pwm_out(pwm_out)
   );

   initial forever begin
      @(negedge clk);
      fast_tick = ~fast_tick;
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [31:0] ctl(input bit en, input int ps, input int src,
                                       input bit doze, input bit wt, input bit dbg);
      ctl = '0;
      ctl[0] = en;
      ctl[15:4] = ps[11:0];
      ctl[17:16] = src[1:0];
      ctl[22] = dbg;
      ctl[23] = wt;
      ctl[24] = doze;
   endfunction

   function automatic bit exp_out(input int i, input int p, input int d, input int r);
      return ((i / r) % (p + 2)) < d;
   endfunction

   // starts at the sample taken right after enable was written
   task automatic check_pattern(input int p, input int d, input int r, input int n, input string tag);
      int bad = -1;
      bit act = 0;
      for (int i = 0; i < n; i++) begin
         if (bad < 0 && pwm_out !== exp_out(i, p, d, r)) begin
            bad = i; act = pwm_out;
         end
         @(negedge clk);
      end
      check(bad < 0, tag, act, bad < 0 ? 0 : exp_out(bad, p, d, r));
   endtask

   task automatic count_high(input int n, output int h);
      h = 0;
      for (int i = 0; i < n; i++) begin
         if (pwm_out) h++;
         @(negedge clk);
      end
   endtask

   task automatic setup(input int p, input int d, input logic [31:0] c);
      wr(8'h00, 32'h0);
      wr(8'h10, p);
      wr(8'h0C, d);
      wr(8'h00, c);
   endtask

   task automatic test_reset();
      logic [31:0] v;
      check(pwm_out === 1'b0, "R1 output after reset", pwm_out, 0);
      rd(8'h00, v); check(v === 0, "R1 control after reset", v, 0);
      rd(8'h0C, v); check(v === 0, "R1 duty after reset", v, 0);
      rd(8'h10, v); check(v === 0, "R1 period after reset", v, 0);
   endtask

   task automatic test_regs();
      logic [31:0] v;
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, v); check(v === 32'h01C3_FFF1, "R2 control mask", v, 32'h01C3_FFF1);
      wr(8'h0C, 32'hFFFF_FFFF);
      rd(8'h0C, v); check(v === 32'h0000_FFFF, "R2 duty mask", v, 32'hFFFF);
      wr(8'h10, 32'hABCD_1234);
      rd(8'h10, v); check(v === 32'h0000_1234, "R2 period mask", v, 32'h1234);
      rd(8'h04, v); check(v === 0, "R2 unmapped read", v, 0);
      wr(8'h00, 32'h0);
   endtask

   task automatic test_basic();
      setup(3, 2, ctl(1, 0, 1, 0, 0, 0));
      check_pattern(3, 2, 1, 20, "R3 R4 period 3 duty 2");
      setup(6, 3, ctl(1, 0, 1, 0, 0, 0));
      check_pattern(6, 3, 1, 24, "R3 R4 period 6 duty 3");
   endtask

   task automatic test_duty_bounds();
      setup(3, 0, ctl(1, 0, 1, 0, 0, 0));
      check_pattern(3, 0, 1, 15, "R5 duty zero low");
      setup(3, 5, ctl(1, 0, 1, 0, 0, 0));
      check_pattern(3, 5, 1, 15, "R5 duty equal period+2 high");
      setup(3, 9, ctl(1, 0, 1, 0, 0, 0));
      check_pattern(3, 9, 1, 15, "R5 duty beyond period high");
   endtask

   task automatic test_prescale();
      setup(2, 1, ctl(1, 2, 1, 0, 0, 0));
      check_pattern(2, 1, 3, 36, "R6 prescale ratio 3");
   endtask

   task automatic test_source();
      int h;
      setup(3, 2, ctl(1, 0, 0, 0, 0, 0));
      check_pattern(3, 9, 1, 20, "R7 source 0 no counting");
      setup(3, 2, ctl(1, 0, 2, 0, 0, 0));
      repeat (3) @(negedge clk);
      count_high(40, h);
      check(h == 16, "R7 fast source half rate", h, 16);
   endtask

   task automatic test_shadow();
      int bad = -1;
      bit act = 0;
      setup(8, 2, ctl(1, 0, 1, 0, 0, 0));
      check(pwm_out === 1'b1, "R8 first sample high", pwm_out, 1);
      @(negedge clk);
      bus_addr = 8'h0C; bus_wdata = 32'd6; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      for (int i = 2; i < 20; i++) begin
         bit e = (i < 10) ? (i < 2) : ((i - 10) < 6);
         if (bad < 0 && pwm_out !== e) begin bad = i; act = pwm_out; end
         @(negedge clk);
      end
      check(bad < 0, "R8 duty takes effect at boundary", act, bad);
   endtask

   task automatic test_enable();
      int h;
      setup(3, 2, ctl(1, 0, 1, 0, 0, 0));
      repeat (3) @(negedge clk);
      wr(8'h00, ctl(0, 0, 1, 0, 0, 0));
      count_high(6, h);
      check(h == 0, "R9 disabled output low", h, 0);
      wr(8'h00, ctl(1, 0, 1, 0, 0, 0));
      check_pattern(3, 2, 1, 10, "R9 re-enable fresh period");
   endtask

   task automatic test_freeze_one(input int which);
      int h;
      bit lvl;
      bit moved = 0;
      string nm = (which == 0) ? "doze" : (which == 1) ? "wait" : "debug";
      setup(3, 2, ctl(1, 0, 1, 0, 0, 0));
      repeat (which + 1) @(negedge clk);
      lvl = pwm_out;
      doze_req = (which == 0); wait_req = (which == 1); dbg_halt = (which == 2);
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (pwm_out !== lvl) moved = 1;
      end
      check(!moved, {"R10 frozen hold ", nm}, moved, 0);
      doze_req = 0; wait_req = 0; dbg_halt = 0;
      @(negedge clk);
      count_high(20, h);
      check(h == 8, {"R10 resumes after ", nm}, h, 8);
      wr(8'h00, ctl(1, 0, 1, which == 0, which == 1, which == 2));
      doze_req = (which == 0); wait_req = (which == 1); dbg_halt = (which == 2);
      count_high(20, h);
      check(h == 8, {"R10 run bit keeps counting ", nm}, h, 8);
      doze_req = 0; wait_req = 0; dbg_halt = 0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_regs();
      test_basic();
      test_duty_bounds();
      test_prescale();
      test_source();
      test_shadow();
      test_enable();
      for (int k = 0; k < 3; k++) test_freeze_one(k);
      finish_run();
   end

endmodule